// File: doc/BRIEF.md
# Serial Byte Capture Trigger with Pretrigger History

This block sits behind an SPI byte decoder and records the MOSI byte stream around an event of interest. Software or a debug controller loads the trigger setup and pulses `arm`. From then on every decoded byte is written into a circular history buffer. While the block waits for its trigger it keeps overwriting the oldest entries. The trigger is one of three kinds: a chosen edge of the chip-select line, a single byte matched under a per-bit mask, or a run of up to four consecutive bytes.

A trigger is accepted only after a programmed number of entries has been gathered. This guarantees history from before the event. Once triggered, the block captures a programmed number of further bytes and then freezes. The frozen window is read back through an address port where address 0 is always the oldest retained byte, so the window comes out in arrival order whatever the write pointer's position.

Top module: `spi_capture_trigger`

## Requirements
- R1: After reset `state` is 0 (idle) and `stored_count` is 0. Bytes presented while idle are not stored.
- R2: A one-cycle `arm` pulse in any state moves `state` to 1 (armed) on the next edge. It clears `stored_count` and the sequence matcher. A byte presented in the same cycle as `arm` is not stored.
- R3: With `trig_mode`=0, the trigger event is a chip-select edge. `edge_sel`=0 selects the high-to-low transition of `cs_n` and `edge_sel`=1 the low-to-high one. The other edge has no effect.
- R4: With `trig_mode`=1, a byte fires when `((byte ^ pat_value) & pat_mask)` is zero, so bits with a mask bit of 0 are ignored.
- R5: With `trig_mode`=2, the event fires on the last byte of `seq_len` (1 to 4) consecutive bytes equal to `seq_bytes[7:0]`, `seq_bytes[15:8]` and onward. A byte that breaks a partial match restarts the match, counting as its first byte if it equals `seq_bytes[7:0]`. A `trig_mode` of 3 never fires.
- R6: An event is accepted only when `stored_count` before that cycle's byte is at least `pre_depth`. Otherwise it is ignored and the block stays armed.
- R7: On an accepted event, `state` becomes 2 (triggered). The byte of that cycle is stored as history. After `post_count` further bytes `state` becomes 3 (done). A `post_count` of 0 goes straight to done. No byte is stored in done.
- R8: `stored_count` equals the number of bytes written since `arm`, saturating at DEPTH. The buffer keeps the most recent DEPTH of them.
- R9: `rd_data` shows the byte at position `rd_addr` of the retained window, with address 0 the oldest and address `stored_count`-1 the newest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new capture (one-cycle pulse) |
| cs_n | input | 1 | Chip-select level, already synchronous to clk |
| byte_valid | input | 1 | A decoded MOSI byte is present this cycle |
| byte_data | input | 8 | Decoded MOSI byte |
| trig_mode | input | 2 | 0 edge, 1 masked pattern, 2 sequence, 3 none |
| edge_sel | input | 1 | 0 falling, 1 rising chip-select edge |
| pat_value | input | 8 | Pattern compare value |
| pat_mask | input | 8 | Pattern compare mask, 1 = compare bit |
| seq_bytes | input | 8*SEQ_MAX | Sequence bytes, first byte in the low byte |
| seq_len | input | LW | Sequence length, 1 to SEQ_MAX |
| pre_depth | input | AW+1 | Minimum history before a trigger is accepted |
| post_count | input | AW+1 | Bytes captured after the trigger |
| rd_addr | input | AW | Readout position, 0 = oldest |
| state | output | 2 | 0 idle, 1 armed, 2 triggered, 3 done |
| stored_count | output | AW+1 | Entries held in the window |
| rd_data | output | 8 | Byte at `rd_addr` |

## Verification
The bench runs long streams that wrap the buffer, so a readout origin taken from the raw pointer instead of the pointer minus the count returns bytes in rotated order. Matches placed before the required history depth catch a design that fires early and leaves too little pre-event history. A repeated first byte ahead of a sequence catches a matcher that drops back to zero without counting the breaking byte, which misses the trigger. Further cases cover a zero post count, bytes sent after done, and the chip-select edge that is not selected: a design that still stores or fires in these cases shows a wrong count or state.

// File: rtl/spi_cap_pkg.sv
package spi_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_TRIG  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  typedef enum logic [1:0] {
    TM_EDGE    = 2'd0,
    TM_PATTERN = 2'd1,
    TM_SEQ     = 2'd2,
    TM_NONE    = 2'd3
  } trig_mode_e;

  // True when every bit selected by the mask agrees.
  function automatic logic masked_equal(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] m);
    return ((a ^ b) & m) == 8'h00;
  endfunction

endpackage

// File: rtl/trig_match.sv
module trig_match
  import spi_cap_pkg::*;
#(
  parameter int SEQ_MAX = 4,
  localparam int LW = $clog2(SEQ_MAX + 1),
  localparam int IW = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   enable,
  input  logic                   cs_n,
  input  logic                   byte_valid,
  input  logic [7:0]             byte_data,
  input  logic [1:0]             mode,
  input  logic                   edge_sel,
  input  logic [7:0]             pat_value,
  input  logic [7:0]             pat_mask,
  input  logic [8*SEQ_MAX-1:0]   seq_bytes,
  input  logic [LW-1:0]          seq_len,
  output logic                   hit
);

  logic          cs_q;
  logic [IW-1:0] idx_q, idx_d;
  logic          edge_ev, pat_ev, seq_ev;
  logic          len_ok, step_ok, first_ok;
  logic [7:0]    want_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign edge_ev = edge_sel ? (cs_n & ~cs_q) : (~cs_n & cs_q);
  assign pat_ev  = byte_valid && masked_equal(byte_data, pat_value, pat_mask);

  assign len_ok    = (seq_len != '0) && (int'(seq_len) <= SEQ_MAX);
  assign want_byte = seq_bytes[8*idx_q +: 8];
  assign step_ok   = byte_data == want_byte;
  assign first_ok  = byte_data == seq_bytes[7:0];

  always_comb begin
    idx_d  = idx_q;
    seq_ev = 1'b0;
    if (enable && byte_valid && len_ok) begin
      if (step_ok) begin
        if (int'(idx_q) + 1 == int'(seq_len)) begin
          seq_ev = 1'b1;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else if (first_ok) begin
        idx_d = IW'(1);
      end else begin
        idx_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) idx_q <= '0;
    else               idx_q <= idx_d;
  end

  always_comb begin
    hit = 1'b0;
    if (enable) begin
      unique case (trig_mode_e'(mode))
        TM_EDGE:    hit = edge_ev;
        TM_PATTERN: hit = pat_ev;
        TM_SEQ:     hit = seq_ev;
        default:    hit = 1'b0;
      endcase
    end
  end

  p_seq_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < SEQ_MAX);

  p_seq_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clr && byte_valid && mode == 2'd2 && !step_ok && first_ok && len_ok)
    |=> idx_q == IW'(1));

  p_mode_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !hit);

endmodule

// File: rtl/cap_buffer.sv
module cap_buffer #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [AW:0]   fill,
  output logic [7:0]    rd_data
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] origin;

  // Oldest slot: write pointer minus the stored count, modulo DEPTH.
  function automatic logic [AW-1:0] oldest_slot(input logic [AW-1:0] ptr,
                                                input logic [AW:0] cnt);
    return AW'((int'(ptr) + DEPTH - (int'(cnt) % DEPTH)) % DEPTH);
  endfunction

  function automatic logic [AW-1:0] slot_of(input logic [AW-1:0] base,
                                            input logic [AW-1:0] ofs);
    return AW'((int'(base) + int'(ofs)) % DEPTH);
  endfunction

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] ptr);
    return AW'((int'(ptr) + 1) % DEPTH);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      fill   <= '0;
    end else if (wr_en) begin
      wr_ptr <= next_ptr(wr_ptr);
      if (int'(fill) < DEPTH) fill <= fill + 1'b1;
    end
  end

  assign origin  = oldest_slot(wr_ptr, fill);
  assign rd_data = mem[slot_of(origin, rd_addr)];

  p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  p_fill_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && int'(fill) < DEPTH) |=> int'(fill) == int'($past(fill)) + 1);

  p_fill_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(fill));

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import spi_cap_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        hit,
  input  logic        byte_valid,
  input  logic [AW:0] fill,
  input  logic [AW:0] pre_depth,
  input  logic [AW:0] post_count,
  output cap_state_e  state,
  output logic        match_en,
  output logic        wr_en,
  output logic        clr
);

  logic [AW:0] post_left;
  logic        ready;
  logic        accept;

  assign ready    = fill >= pre_depth;
  assign match_en = (state == ST_ARMED) && !arm;
  assign accept   = hit && ready;
  assign clr      = arm;
  assign wr_en    = byte_valid && !arm && (state == ST_ARMED || state == ST_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      post_left <= '0;
    end else if (arm) begin
      state     <= ST_ARMED;
      post_left <= '0;
    end else begin
      unique case (state)
        ST_ARMED: if (accept) begin
          post_left <= post_count;
          state     <= (post_count == '0) ? ST_DONE : ST_TRIG;
        end
        ST_TRIG: if (byte_valid) begin
          post_left <= post_left - 1'b1;
          if (post_left == AW'(1)) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  p_arm_enters_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> state == ST_ARMED && fill == '0);

  p_trig_needs_history_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !arm) |=> (state == ST_ARMED || $past(fill) >= $past(pre_depth)));

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && !arm) |=> state == ST_DONE && $stable(fill));

  p_post_waits_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIG && !byte_valid && !arm) |=> state == ST_TRIG);

endmodule

// File: rtl/spi_capture_trigger.sv
module spi_capture_trigger
  import spi_cap_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int SEQ_MAX = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(SEQ_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 cs_n,
  input  logic                 byte_valid,
  input  logic [7:0]           byte_data,
  input  logic [1:0]           trig_mode,
  input  logic                 edge_sel,
  input  logic [7:0]           pat_value,
  input  logic [7:0]           pat_mask,
  input  logic [8*SEQ_MAX-1:0] seq_bytes,
  input  logic [LW-1:0]        seq_len,
  input  logic [AW:0]          pre_depth,
  input  logic [AW:0]          post_count,
  input  logic [AW-1:0]        rd_addr,
  output logic [1:0]           state,
  output logic [AW:0]          stored_count,
  output logic [7:0]           rd_data
);

  cap_state_e st;
  logic       hit;
  logic       match_en;
  logic       wr_en;
  logic       clr;
  logic [AW:0] fill;

  trig_match #(.SEQ_MAX(SEQ_MAX)) u_match (
    .clk(clk), .rst_n(rst_n), .clr(clr), .enable(match_en), .cs_n(cs_n),
    .byte_valid(byte_valid), .byte_data(byte_data), .mode(trig_mode),
    .edge_sel(edge_sel), .pat_value(pat_value), .pat_mask(pat_mask),
    .seq_bytes(seq_bytes), .seq_len(seq_len), .hit(hit)
  );

  capture_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .byte_valid(byte_valid),
    .fill(fill), .pre_depth(pre_depth), .post_count(post_count),
    .state(st), .match_en(match_en), .wr_en(wr_en), .clr(clr)
  );

  cap_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(byte_data),
    .rd_addr(rd_addr), .fill(fill), .rd_data(rd_data)
  );

  assign state        = st;
  assign stored_count = fill;

  p_idle_no_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0 && !arm) |=> $stable(stored_count) && state == 2'd0);

endmodule

// File: tb/sim_spi_capture_trigger.sv
module sim_spi_capture_trigger;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] val;
    logic [7:0] mask;
    logic [2:0] slen;
    logic [4:0] pre;
    logic [4:0] post;
    logic [7:0] nbytes;
    logic [1:0] exp_state;
    logic [4:0] exp_cnt;
    logic [7:0] exp_first;
    logic [7:0] exp_last;
  } vec_t;

  // Stream byte i is 0x10+i. Sequence rows use val, val+1, val+2.
  localparam vec_t VECS [9] = '{
    '{2'd1, 8'h15, 8'hFF, 3'd0, 5'd2, 5'd3, 8'd12, 2'd3, 5'd9,  8'h10, 8'h18}, // R4 R7
    '{2'd1, 8'h25, 8'hFF, 3'd0, 5'd0, 5'd4, 8'd30, 2'd3, 5'd16, 8'h1A, 8'h29}, // R8 R9 wrap
    '{2'd1, 8'h12, 8'hFF, 3'd0, 5'd5, 5'd1, 8'd10, 2'd1, 5'd10, 8'h10, 8'h19}, // R6
    '{2'd1, 8'h2F, 8'hF0, 3'd0, 5'd0, 5'd2, 8'd25, 2'd3, 5'd16, 8'h13, 8'h22}, // R4 mask
    '{2'd2, 8'h14, 8'h00, 3'd3, 5'd0, 5'd1, 8'd10, 2'd3, 5'd8,  8'h10, 8'h17}, // R5
    '{2'd2, 8'h14, 8'h00, 3'd3, 5'd8, 5'd1, 8'd12, 2'd1, 5'd12, 8'h10, 8'h1B}, // R6 seq
    '{2'd1, 8'h13, 8'hFF, 3'd0, 5'd0, 5'd0, 8'd8,  2'd3, 5'd4,  8'h10, 8'h13}, // R7 post 0
    '{2'd3, 8'h10, 8'hFF, 3'd0, 5'd0, 5'd1, 8'd5,  2'd1, 5'd5,  8'h10, 8'h14}, // R5 none
    '{2'd1, 8'h11, 8'hFF, 3'd0, 5'd0, 5'd5, 8'd3,  2'd2, 5'd3,  8'h10, 8'h12}  // R7 mid
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        cs_n = 1'b1;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [1:0]  trig_mode = '0;
  logic        edge_sel = 1'b0;
  logic [7:0]  pat_value = '0;
  logic [7:0]  pat_mask = '0;
  logic [31:0] seq_bytes = '0;
  logic [2:0]  seq_len = '0;
  logic [4:0]  pre_depth = '0;
  logic [4:0]  post_count = '0;
  logic [3:0]  rd_addr = '0;
  logic [1:0]  state;
  logic [4:0]  stored_count;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_capture_trigger #(.DEPTH(16), .SEQ_MAX(4)) u0 (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cs_n(cs_n), .byte_valid(byte_valid),
    .byte_data(byte_data), .trig_mode(trig_mode), .edge_sel(edge_sel),
    .pat_value(pat_value), .pat_mask(pat_mask), .seq_bytes(seq_bytes),
    .seq_len(seq_len), .pre_depth(pre_depth), .post_count(post_count),
    .rd_addr(rd_addr), .state(state), .stored_count(stored_count), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic read_at(input int a, output int d);
    rd_addr = 4'(a);
    #1;
    d = int'(rd_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and idle bytes ignored
    chk("R1 state after reset", int'(state), 0);
    chk("R1 count after reset", int'(stored_count), 0);
    send_byte(8'h55);
    send_byte(8'h66);
    chk("R1 idle bytes not stored", int'(stored_count), 0);
    chk("R1 still idle", int'(state), 0);

    // Table walk
    foreach (VECS[k]) begin
      trig_mode  = VECS[k].mode;
      pat_value  = VECS[k].val;
      pat_mask   = VECS[k].mask;
      seq_bytes  = {8'h00, VECS[k].val + 8'd2, VECS[k].val + 8'd1, VECS[k].val};
      seq_len    = VECS[k].slen;
      pre_depth  = VECS[k].pre;
      post_count = VECS[k].post;
      do_arm();
      chk($sformatf("R2 armed row %0d", k), int'(state), 1);
      chk($sformatf("R2 cleared row %0d", k), int'(stored_count), 0);
      for (int i = 0; i < int'(VECS[k].nbytes); i++) send_byte(8'h10 + 8'(i));
      chk($sformatf("R7 state row %0d", k), int'(state), int'(VECS[k].exp_state));
      chk($sformatf("R8 count row %0d", k), int'(stored_count), int'(VECS[k].exp_cnt));
      read_at(0, d);
      chk($sformatf("R9 oldest row %0d", k), d, int'(VECS[k].exp_first));
      read_at(int'(VECS[k].exp_cnt) - 1, d);
      chk($sformatf("R9 newest row %0d", k), d, int'(VECS[k].exp_last));
      @(negedge clk);
    end

    // R2: byte in the arm cycle is not stored
    trig_mode = 2'd3;
    arm = 1'b1; byte_valid = 1'b1; byte_data = 8'hAA;
    @(negedge clk);
    arm = 1'b0; byte_valid = 1'b0;
    chk("R2 arm-cycle byte dropped", int'(stored_count), 0);

    // R3: falling edge fires
    trig_mode = 2'd0; edge_sel = 1'b0; pre_depth = 5'd2; post_count = 5'd2;
    cs_n = 1'b1;
    do_arm();
    for (int i = 0; i < 3; i++) send_byte(8'hC0 + 8'(i));
    cs_n = 1'b0;
    @(negedge clk);
    chk("R3 falling edge triggers", int'(state), 2);
    send_byte(8'hD0);
    send_byte(8'hD1);
    chk("R3 done after post bytes", int'(state), 3);
    chk("R3 count", int'(stored_count), 5);
    read_at(4, d);
    chk("R9 edge newest", d, 'hD1);

    // R3: rising selected, falling ignored
    cs_n = 1'b1; @(negedge clk);
    edge_sel = 1'b1; pre_depth = 5'd0; post_count = 5'd1;
    do_arm();
    cs_n = 1'b0; @(negedge clk);
    chk("R3 other edge ignored", int'(state), 1);
    cs_n = 1'b1; @(negedge clk);
    chk("R3 rising edge triggers", int'(state), 2);

    // R6: falling edge before enough history is ignored
    edge_sel = 1'b0; pre_depth = 5'd2; post_count = 5'd1;
    do_arm();
    send_byte(8'h01);
    cs_n = 1'b0; @(negedge clk);
    chk("R6 early edge ignored", int'(state), 1);
    cs_n = 1'b1; @(negedge clk);

    // R5: restart on repeated first byte
    trig_mode = 2'd2; seq_bytes = {16'h0000, 8'h42, 8'h41}; seq_len = 3'd2;
    pre_depth = 5'd0; post_count = 5'd1;
    do_arm();
    send_byte(8'h41); send_byte(8'h41); send_byte(8'h42);
    chk("R5 restart keeps breaking byte", int'(state), 2);

    // R5: four-byte sequence, broken then complete
    seq_bytes = 32'h04030201; seq_len = 3'd4;
    do_arm();
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h05);
    chk("R5 broken run no fire", int'(state), 1);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h04);
    chk("R5 four-byte run fires", int'(state), 2);

    // R2: re-arm during triggered clears everything
    do_arm();
    chk("R2 re-arm state", int'(state), 1);
    chk("R2 re-arm count", int'(stored_count), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule